// File: doc/BRIEF.md
# Multi-Head Slotted Transmit Queue

This block is the transmit queue of one egress port in a packet fabric. Its storage is split into equal slots, each sized to the packet size the network has negotiated. A fast internal router delivers bytes to it from several sources at once over a small number of independent write heads. Each head starts a packet by claiming a free slot and then writes one byte per cycle into that slot, whatever the other heads are doing. A packet becomes visible to the single reader only once its final byte has been written. The reader then streams whole packets out toward the slower serial link, in the order in which they finished.

There is no back-pressure toward the router. If no slot is free when a packet starts, that packet is discarded completely and the head reports the loss on a one-cycle pulse. Each egress port has its own instance, so ports share no storage.

Capacity, slot size and the number of heads are package parameters. The deployed configuration is a 16 KB queue holding 16 to 128 slots, with three or four heads. The default build is smaller so that it elaborates quickly: 3 heads, 2 KB, and 16 slots of 128 bytes.

Top module: `slot_tx_queue`

## Requirements
- R1: While reset is held, and right after it is released, `rdValid` is low and every bit of `dropPulse` is low.
- R2: A stored packet is read back byte for byte as written. Its length can be anything from 1 to the slot size. `rdSop` marks its first byte and `rdEop` marks its last byte, and a 1-byte packet shows both flags together.
- R3: Head h uses `inValid[h]`, `inSop[h]`, `inEop[h]` and the byte lane `inData[8h+7:8h]`. All heads can write different packets in the same cycles, one byte per head per cycle, without disturbing each other.
- R4: Packets are read in the order in which their final bytes were accepted. A packet whose final byte is accepted at a clock edge can be read from the next cycle. This holds even when a read removes another packet at that same edge.
- R5: When several packets finish in the same cycle, the one on the lower-numbered head is read first.
- R6: When several heads start packets in the same cycle and there are not enough free slots, the lower-numbered heads get slots first. The remaining heads are dropped.
- R7: A start byte that finds no free slot causes that whole packet to be discarded. `dropPulse[h]` goes high for the one cycle after that start byte.
- R8: The queue holds exactly QUEUE_BYTES/SLOT_BYTES packets (16 by default), however short those packets are.
- R9: A slot is released when its last byte is read, meaning `rdValid`, `rdReady` and `rdEop` are all high. A new packet can claim that slot from the next cycle. A start byte in the same cycle as the releasing read still finds the queue full.
- R10: While `rdValid` is high and `rdReady` is low, `rdValid`, `rdData`, `rdSop` and `rdEop` hold their values.
- R11: Bytes that arrive on a head with no claimed slot and no start flag are ignored. This includes a stray end byte, and none of these bytes ever appear at the reader.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | HEADS | Byte valid, one bit per head |
| inSop | input | HEADS | First byte of a packet, per head |
| inEop | input | HEADS | Last byte of a packet, per head |
| inData | input | 8*HEADS | Byte lanes, head h in bits 8h+7:8h |
| dropPulse | output | HEADS | One-cycle pulse per head when its packet was discarded |
| rdValid | output | 1 | Reader byte available |
| rdData | output | 8 | Reader byte |
| rdSop | output | 1 | Reader byte is the first of its packet |
| rdEop | output | 1 | Reader byte is the last of its packet |
| rdReady | input | 1 | Reader accepts the current byte |

## Verification
Slot traffic can collide in two ways within a single cycle. A head can finish a packet at the same edge where the reader removes another packet from the ready list. A head can also claim a slot at the same edge where the reader releases one. The first collision is set up by reading a stored packet while a second head's final byte lands on the reader's last byte. The second packet must then be readable, with its start flag, in the very next cycle. The second collision is set up with a full queue by raising `rdReady` on a 1-byte packet while a head starts a new one. That start must be dropped, and an identical start one cycle later must be stored and read back after the older packets.

// File: rtl/slot_txq_pkg.sv
package slot_txq_pkg;

  parameter int unsigned HEADS       = 3;
  parameter int unsigned QUEUE_BYTES = 2048;
  parameter int unsigned SLOT_BYTES  = 128;

  localparam int unsigned SLOTS  = QUEUE_BYTES / SLOT_BYTES;
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned OFF_W  = $clog2(SLOT_BYTES);
  localparam int unsigned ADDR_W = SLOT_W + OFF_W;
  localparam int unsigned LEN_W  = OFF_W + 1;
  localparam int unsigned DEPTH  = SLOTS * SLOT_BYTES;

  typedef enum logic [1:0] {
    HEAD_IDLE,
    HEAD_FILL,
    HEAD_SKIP
  } head_state_e;

  // Strobes from the control to the byte store
  typedef struct packed {
    logic [HEADS-1:0]             wrEn;
    logic [HEADS-1:0][ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0]            rdAddr;
  } mem_strobe_t;

endpackage

// File: rtl/slot_txq_mem.sv
module slot_txq_mem
  import slot_txq_pkg::*;
(
  input  logic              clk,
  input  mem_strobe_t       strobe,
  input  logic [HEADS*8-1:0] wrData,
  output logic [7:0]        rdData
);

  logic [7:0] store [DEPTH];

  // One write port per head; heads never share a slot
  always_ff @(posedge clk) begin
    for (int h = 0; h < HEADS; h++) begin
      if (strobe.wrEn[h]) begin
        store[strobe.wrAddr[h]] <= wrData[h*8 +: 8];
      end
    end
  end

  assign rdData = store[strobe.rdAddr];

endmodule

// File: rtl/slot_txq_ctrl.sv
module slot_txq_ctrl
  import slot_txq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [HEADS-1:0] inValid,
  input  logic [HEADS-1:0] inSop,
  input  logic [HEADS-1:0] inEop,
  output logic [HEADS-1:0] dropPulse,
  input  logic             rdReady,
  output logic             rdValid,
  output logic             rdSop,
  output logic             rdEop,
  output mem_strobe_t      strobe
);

  // Per-head write context
  head_state_e       hState [HEADS];
  logic [SLOT_W-1:0] hSlot  [HEADS];
  logic [OFF_W-1:0]  hPtr   [HEADS];

  // Slot pool and allocation
  logic [SLOTS-1:0]  freeMap;
  logic [SLOTS-1:0]  allocMask;
  logic [SLOTS-1:0]  releaseMask;
  logic [HEADS-1:0]  claim;
  logic [HEADS-1:0]  grant;
  logic [SLOT_W-1:0] grantSlot [HEADS];

  // Completion bookkeeping
  logic [HEADS-1:0]  done;
  logic [SLOT_W-1:0] doneSlot [HEADS];
  logic [LEN_W-1:0]  doneLen  [HEADS];
  logic [SLOT_W-1:0] pushPos  [HEADS];
  logic [SLOT_W:0]   pushTotal;

  // Ready list of finished slots
  logic [SLOT_W-1:0] readySlot [SLOTS];
  logic [LEN_W-1:0]  readyLen  [SLOTS];
  logic [SLOT_W-1:0] readyWr;
  logic [SLOT_W-1:0] readyRd;
  logic [SLOT_W:0]   readyCnt;

  // Reader cursor
  logic [OFF_W-1:0]  rdOff;
  logic [SLOT_W-1:0] curSlot;
  logic [LEN_W-1:0]  curLen;
  logic              pop;

  function automatic logic [SLOT_W-1:0] lowestFree(input logic [SLOTS-1:0] v);
    lowestFree = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (v[s]) lowestFree = SLOT_W'(s);
    end
  endfunction

  // Allocation: heads served in index order, each takes the lowest free slot
  always_comb begin
    logic [SLOTS-1:0] avail;
    avail     = freeMap;
    allocMask = '0;
    for (int h = 0; h < HEADS; h++) begin
      claim[h]     = inValid[h] & inSop[h] & (hState[h] != HEAD_FILL);
      grant[h]     = 1'b0;
      grantSlot[h] = lowestFree(avail);
      if (claim[h] && (avail != '0)) begin
        grant[h]                = 1'b1;
        avail[grantSlot[h]]     = 1'b0;
        allocMask[grantSlot[h]] = 1'b1;
      end
    end
  end

  // Reader view of the oldest finished packet
  assign curSlot     = readySlot[readyRd];
  assign curLen      = readyLen[readyRd];
  assign rdValid     = (readyCnt != '0);
  assign rdSop       = rdValid && (rdOff == '0);
  assign rdEop       = rdValid && (({1'b0, rdOff} + LEN_W'(1)) == curLen);
  assign pop         = rdEop && rdReady;
  assign releaseMask = pop ? (SLOTS'(1) << curSlot) : '0;

  // Write strobes, completions and the read address
  always_comb begin
    strobe = '0;
    for (int h = 0; h < HEADS; h++) begin
      doneSlot[h] = hSlot[h];
      doneLen[h]  = {1'b0, hPtr[h]} + LEN_W'(1);
      if (claim[h]) begin
        strobe.wrEn[h]   = grant[h];
        strobe.wrAddr[h] = {grantSlot[h], OFF_W'(0)};
        doneSlot[h]      = grantSlot[h];
        doneLen[h]       = LEN_W'(1);
      end else if (inValid[h] && (hState[h] == HEAD_FILL)) begin
        strobe.wrEn[h]   = 1'b1;
        strobe.wrAddr[h] = inSop[h] ? {hSlot[h], OFF_W'(0)} : {hSlot[h], hPtr[h]};
        if (inSop[h]) doneLen[h] = LEN_W'(1);
      end
      done[h] = strobe.wrEn[h] & inEop[h];
    end
    strobe.rdAddr = {curSlot, rdOff};
  end

  // Completions enter the ready list in head order
  always_comb begin
    logic [SLOT_W-1:0] acc;
    acc       = readyWr;
    pushTotal = '0;
    for (int h = 0; h < HEADS; h++) begin
      pushPos[h] = acc;
      if (done[h]) begin
        acc       = acc + SLOT_W'(1);
        pushTotal = pushTotal + (SLOT_W + 1)'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int h = 0; h < HEADS; h++) begin
      if (done[h]) begin
        readySlot[pushPos[h]] <= doneSlot[h];
        readyLen[pushPos[h]]  <= doneLen[h];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMap  <= '1;
      readyWr  <= '0;
      readyRd  <= '0;
      readyCnt <= '0;
      rdOff    <= '0;
    end else begin
      freeMap  <= (freeMap & ~allocMask) | releaseMask;
      readyWr  <= readyWr + pushTotal[SLOT_W-1:0];
      readyCnt <= readyCnt + pushTotal - {{SLOT_W{1'b0}}, pop};
      if (rdValid && rdReady) begin
        rdOff <= rdEop ? '0 : rdOff + OFF_W'(1);
      end
      if (pop) begin
        readyRd <= readyRd + SLOT_W'(1);
      end
    end
  end

  // Per-head state machines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int h = 0; h < HEADS; h++) begin
        hState[h]    <= HEAD_IDLE;
        hSlot[h]     <= '0;
        hPtr[h]      <= '0;
        dropPulse[h] <= 1'b0;
      end
    end else begin
      for (int h = 0; h < HEADS; h++) begin
        dropPulse[h] <= 1'b0;
        if (inValid[h]) begin
          if (claim[h]) begin
            if (grant[h]) begin
              hSlot[h]  <= grantSlot[h];
              hPtr[h]   <= OFF_W'(1);
              hState[h] <= inEop[h] ? HEAD_IDLE : HEAD_FILL;
            end else begin
              dropPulse[h] <= 1'b1;
              hState[h]    <= inEop[h] ? HEAD_IDLE : HEAD_SKIP;
            end
          end else if (hState[h] == HEAD_FILL) begin
            hPtr[h] <= inSop[h] ? OFF_W'(1) : hPtr[h] + OFF_W'(1);
            if (inEop[h]) hState[h] <= HEAD_IDLE;
          end else if ((hState[h] == HEAD_SKIP) && inEop[h]) begin
            hState[h] <= HEAD_IDLE;
          end
        end
      end
    end
  end

endmodule

// File: rtl/slot_tx_queue.sv
module slot_tx_queue
  import slot_txq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [HEADS-1:0]   inValid,
  input  logic [HEADS-1:0]   inSop,
  input  logic [HEADS-1:0]   inEop,
  input  logic [HEADS*8-1:0] inData,
  output logic [HEADS-1:0]   dropPulse,
  output logic               rdValid,
  output logic [7:0]         rdData,
  output logic               rdSop,
  output logic               rdEop,
  input  logic               rdReady
);

  mem_strobe_t strobe;

  slot_txq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSop     (inSop),
    .inEop     (inEop),
    .dropPulse (dropPulse),
    .rdReady   (rdReady),
    .rdValid   (rdValid),
    .rdSop     (rdSop),
    .rdEop     (rdEop),
    .strobe    (strobe)
  );

  slot_txq_mem u_mem (
    .clk    (clk),
    .strobe (strobe),
    .wrData (inData),
    .rdData (rdData)
  );

endmodule

// File: rtl/slot_tx_queue_chk.sv
module slot_tx_queue_chk
  import slot_txq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [HEADS-1:0] inValid,
  input logic [HEADS-1:0] inSop,
  input logic [HEADS-1:0] dropPulse,
  input logic             rdValid,
  input logic [7:0]       rdData,
  input logic             rdSop,
  input logic             rdEop,
  input logic             rdReady
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!rdValid && (dropPulse == '0)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData) && $stable(rdSop) && $stable(rdEop)));

  assert_next_is_sop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && rdEop) |=> (!rdValid || rdSop));

  assert_mid_packet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && !rdEop) |=> (rdValid && !rdSop));

  assert_fall_after_eop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdValid) |-> $past(rdReady && rdEop));

  for (genvar g = 0; g < HEADS; g++) begin : gen_drop
    assert_drop_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
      dropPulse[g] |-> $past(inValid[g] && inSop[g]));
  end

endmodule

bind slot_tx_queue slot_tx_queue_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inSop     (inSop),
  .dropPulse (dropPulse),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .rdSop     (rdSop),
  .rdEop     (rdEop),
  .rdReady   (rdReady)
);

// File: tb/tb_slot_tx_queue.sv
module tb_slot_tx_queue;
  import slot_txq_pkg::*;

  localparam int NH = HEADS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic [NH-1:0]     inValid, inSop, inEop;
  logic [NH*8-1:0]   inData;
  logic [NH-1:0]     dropPulse;
  logic              rdValid, rdSop, rdEop, rdReady;
  logic [7:0]        rdData;

  int nRun  = 0;
  int nFail = 0;

  slot_tx_queue dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inData(inData), .dropPulse(dropPulse), .rdValid(rdValid), .rdData(rdData),
    .rdSop(rdSop), .rdEop(rdEop), .rdReady(rdReady)
  );

  function automatic logic [7:0] pat(int tag, int i);
    return 8'((tag * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    inValid = '0; inSop = '0; inEop = '0; inData = '0;
  endtask

  task automatic driveByte(int h, bit sop, bit eop, logic [7:0] d);
    inValid[h] = 1'b1; inSop[h] = sop; inEop[h] = eop; inData[h*8 +: 8] = d;
  endtask

  // Drive each head's packet from its start cycle; collect drop pulses
  task automatic runHeads(input int st[NH], input int ln[NH], input int tg[NH],
                          output logic [NH-1:0] drops);
    int last = 0;
    drops = '0;
    for (int h = 0; h < NH; h++)
      if (ln[h] > 0 && st[h] + ln[h] > last) last = st[h] + ln[h];
    for (int c = 0; c < last; c++) begin
      idleInputs();
      for (int h = 0; h < NH; h++) begin
        int i = c - st[h];
        if (ln[h] > 0 && i >= 0 && i < ln[h]) driveByte(h, i == 0, i == ln[h] - 1, pat(tg[h], i));
      end
      tick();
      drops |= dropPulse;
    end
    idleInputs();
  endtask

  task automatic writeOne(int h, int tag, int len);
    logic [NH-1:0] d;
    int st[NH]; int ln[NH]; int tg[NH];
    for (int k = 0; k < NH; k++) begin st[k] = 0; ln[k] = 0; tg[k] = 0; end
    ln[h] = len; tg[h] = tag;
    runHeads(st, ln, tg, d);
  endtask

  // Read one packet; optionally stall two cycles before byte stallAt
  task automatic readPacket(int tag, int len, int stallAt, string req);
    int bad = 0; int act = 0; int exp = 0;
    logic [7:0] snap;
    for (int i = 0; i < len; i++) begin
      if (i == stallAt) begin
        rdReady = 1'b0;
        snap = rdData;
        tick(); tick();
        check(rdValid && rdData == snap && rdSop == (i == 0), "R10",
              "held byte during stall", int'(rdData), int'(snap));
      end
      rdReady = 1'b1;
      if (!rdValid || rdData != pat(tag, i) || rdSop != (i == 0) || rdEop != (i == len - 1)) begin
        if (bad == 0) begin act = rdValid ? int'(rdData) : -1; exp = int'(pat(tag, i)); end
        bad++;
      end
      tick();
    end
    rdReady = 1'b0;
    check(bad == 0, req, $sformatf("packet %0d len %0d bytes/flags", tag, len), act, exp);
  endtask

  task automatic checkEmpty(string req);
    check(!rdValid, req, "queue empty", int'(rdValid), 0);
  endtask

  task automatic testReset();
    check(!rdValid, "R1", "rdValid in reset", int'(rdValid), 0);
    check(dropPulse == '0, "R1", "dropPulse in reset", int'(dropPulse), 0);
    rstN = 1'b1;
    tick();
    check(!rdValid && dropPulse == '0, "R1", "idle after reset", int'(rdValid), 0);
  endtask

  task automatic testSingle();
    writeOne(0, 1, 5);
    check(rdValid && rdSop, "R4", "readable cycle after last byte", int'(rdValid), 1);
    readPacket(1, 5, -1, "R2");
    checkEmpty("R2");
  endtask

  task automatic testInterleave();
    logic [NH-1:0] d;
    runHeads('{0, 2, 1}, '{10, 4, 6}, '{10, 11, 12}, d);
    check(d == '0, "R3", "no drops with concurrent heads", int'(d), 0);
    readPacket(11, 4, -1, "R4");
    readPacket(12, 6, -1, "R4");
    readPacket(10, 10, -1, "R3");
    checkEmpty("R3");
  endtask

  task automatic testTie();
    logic [NH-1:0] d;
    runHeads('{0, 0, 2}, '{5, 5, 3}, '{20, 21, 22}, d);
    readPacket(20, 5, -1, "R5");
    readPacket(21, 5, -1, "R5");
    readPacket(22, 3, -1, "R5");
    checkEmpty("R5");
  endtask

  task automatic testLengths();
    logic [NH-1:0] d;
    runHeads('{0, 0, 0}, '{1, SLOT_BYTES, 0}, '{30, 31, 0}, d);
    check(rdValid && rdSop && rdEop, "R2", "single-byte packet flags", int'({rdSop, rdEop}), 3);
    readPacket(30, 1, -1, "R2");
    readPacket(31, SLOT_BYTES, 3, "R2");
    checkEmpty("R2");
  endtask

  task automatic testStray();
    logic [NH-1:0] seen = '0;
    for (int k = 0; k < 3; k++) begin
      idleInputs(); driveByte(2, 1'b0, 1'b0, 8'hA5); tick(); seen |= dropPulse;
    end
    idleInputs(); driveByte(2, 1'b0, 1'b1, 8'h5A); tick(); seen |= dropPulse;
    idleInputs(); tick(); seen |= dropPulse;
    check(!rdValid, "R11", "stray bytes not stored", int'(rdValid), 0);
    check(seen == '0, "R11", "stray bytes raise no drop", int'(seen), 0);
    writeOne(2, 40, 3);
    readPacket(40, 3, -1, "R11");
    checkEmpty("R11");
  endtask

  task automatic testFull();
    for (int k = 0; k < SLOTS; k++) writeOne(0, 100 + k, 2);
    driveByte(1, 1'b1, 1'b0, pat(50, 0));
    tick();
    check(dropPulse == NH'(2), "R7", "drop pulse after start on full queue", int'(dropPulse), 2);
    idleInputs(); driveByte(1, 1'b0, 1'b1, pat(50, 1));
    tick();
    idleInputs();
    check(dropPulse == '0, "R7", "drop pulse lasts one cycle", int'(dropPulse), 0);
    for (int k = 0; k < SLOTS; k++) readPacket(100 + k, 2, -1, "R8");
    checkEmpty("R7");
  endtask

  task automatic testPriority();
    logic [NH-1:0] d;
    for (int k = 0; k < SLOTS - 1; k++) writeOne(0, 60 + k, 1);
    runHeads('{0, 0, 0}, '{2, 2, 2}, '{80, 81, 82}, d);
    check(d == NH'(6), "R6", "higher heads dropped on last slot", int'(d), 6);
    for (int k = 0; k < SLOTS - 1; k++) readPacket(60 + k, 1, -1, "R6");
    readPacket(80, 2, -1, "R6");
    checkEmpty("R6");
  endtask

  task automatic testFreeTiming();
    for (int k = 0; k < SLOTS; k++) writeOne(1, 120 + k, 1);
    rdReady = 1'b1;
    driveByte(0, 1'b1, 1'b1, pat(90, 0));
    tick();
    rdReady = 1'b0;
    idleInputs();
    check(dropPulse == NH'(1), "R9", "start during releasing read is dropped", int'(dropPulse), 1);
    driveByte(0, 1'b1, 1'b1, pat(91, 0));
    tick();
    idleInputs();
    check(dropPulse == '0, "R9", "start one cycle later is accepted", int'(dropPulse), 0);
    for (int k = 1; k < SLOTS; k++) readPacket(120 + k, 1, -1, "R9");
    readPacket(91, 1, -1, "R9");
    checkEmpty("R9");
  endtask

  task automatic testOverlap();
    logic [NH-1:0] d;
    writeOne(0, 70, 3);
    fork
      readPacket(70, 3, -1, "R4");
      runHeads('{0, 0, 0}, '{0, 3, 0}, '{0, 71, 0}, d);
    join
    check(rdValid && rdSop, "R4", "finish and pop in one cycle", int'(rdValid), 1);
    readPacket(71, 3, -1, "R4");
    checkEmpty("R4");
  endtask

  initial begin
    #1_500_000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    rdReady = 1'b0;
    idleInputs();
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testSingle();
    testInterleave();
    testTie();
    testLengths();
    testStray();
    testFull();
    testPriority();
    testFreeTiming();
    testOverlap();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule